// File: doc/BRIEF.md
# Shared-Sequence Interrupt Controller

This block decides when an 8-bit microcoded CPU enters its single interrupt routine. It tracks that routine while it runs. Power-on reset, a reset request, the non-maskable interrupt and the maskable interrupt all run the same microcode steps as a software break instruction. The controller marks a hardware entry by clearing the opcode register, so the break routine runs as an implied instruction. It then supplies the few values that differ between the sources: the low byte of the jump vector, suppression of stack writes while a reset is served, and whether the program counter advances and the break bit is set in the pushed status byte.

Requests are looked at only at instruction boundaries. A boundary is the cycle in which the sequencer's end strobe says the state counter returns to zero. A reset request wins over the non-maskable interrupt. The non-maskable interrupt wins over the maskable one, and the maskable one counts only while the interrupt-disable flag is clear. A prefetch-inhibit output tells the sequencer to hold the program counter and to skip no states, so that a pending or fresh interrupt really starts in state zero. All pins are plain control and status lines. No data stream passes through the block, so it has no handshake.

Top module: `intr_seq_ctrl`

## Requirements
- R1: After `arst_n` is released, a reset is pending. `int_act_o`, `rst_inp_o` and `nmi_inp_o` are low, and `inh_pf_o` is high.
- R2: If any request is pending in a cycle with `end_seq_i` high, `int_act_o` is high from the next cycle on. `ir_clr_o` always equals `int_act_o`.
- R3: Priority at a boundary is reset request, then NMI, then IRQ. `rst_inp_o` is set when a reset is taken and `nmi_inp_o` when an NMI is taken. The two are never high together.
- R4: IRQ is level sensitive and is not latched. It counts as pending only in a cycle where `irq_i` is high and `i_flag_i` is low.
- R5: A rising edge of `nmi_i` (low in one cycle, high in the next) is latched until an NMI is taken. A held-high level gives only one request. An edge in the same cycle as an NMI is taken leaves a new request pending.
- R6: `rst_req_i` high in a cycle makes a reset pending from the next cycle on. A reset taken while `rst_req_i` is still high leaves a reset pending.
- R7: `int_act_o`, `rst_inp_o` and `nmi_inp_o` change only in the cycle after `end_seq_i` is high. If nothing is pending in that cycle, all three go low.
- R8: `vec_lo_o` is 8'hFC while `rst_inp_o` is high, 8'hFA while `nmi_inp_o` is high, and 8'hFE otherwise.
- R9: `stk_wr_inh_o` is high exactly while `rst_inp_o` is high.
- R10: `pc_adv_o` and `brk_flag_o` are high only while `int_act_o` is low, so only a software break advances the program counter and sets the break bit.
- R11: `inh_pf_o` is high when a request is pending, or when `int_act_o` is high and `q_i` is 0 or 1.
- R12: If a request is pending when a running interrupt sequence ends, the next sequence starts at once. `int_act_o` stays high and the type flags switch to the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req_i | input | 1 | Reset request level |
| nmi_i | input | 1 | Non-maskable interrupt line, edge detected |
| irq_i | input | 1 | Maskable interrupt line, level |
| i_flag_i | input | 1 | Interrupt-disable flag from the status register |
| q_i | input | Q_W | Current microcode state |
| end_seq_i | input | 1 | Sequencer returns Q to zero next cycle |
| int_act_o | output | 1 | Hardware interrupt sequence active |
| rst_inp_o | output | 1 | Reset sequence in progress |
| nmi_inp_o | output | 1 | NMI sequence in progress |
| ir_clr_o | output | 1 | Clear opcode register (implied break) |
| vec_lo_o | output | 8 | Low byte of the vector address |
| stk_wr_inh_o | output | 1 | Suppress stack memory writes |
| pc_adv_o | output | 1 | Allow program-counter advance in the break routine |
| brk_flag_o | output | 1 | Break bit for the pushed status byte |
| inh_pf_o | output | 1 | Inhibit prefetch, PC increment and skip-to-1 |

## Verification
The collision of interest is a boundary that ends a running sequence while a new request is already pending. In that cycle the end-of-service clear of the type flags and the capture of the new source fall together. A second collision is an NMI edge that arrives in the very cycle an earlier NMI is captured. The bench provokes both on purpose: it raises `end_seq_i` during an active reset or NMI sequence with another line asserted, and it pulses `nmi_i` in step with a boundary. Random traffic repeats these cases many times. A behavioural model of pending, in-progress and output values is compared with every output on every cycle, so a lost or double-counted request shows up as a flag or vector mismatch.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RST  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_IRQ  = 2'd3
  } src_e;

  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_LO_RST = 8'hFC;
  localparam logic [VEC_W-1:0] VEC_LO_NMI = 8'hFA;
  localparam logic [VEC_W-1:0] VEC_LO_IRQ = 8'hFE;
endpackage

// File: rtl/intr_pend_latch.sv
// Holds the pending state of each request source between boundaries.
module intr_pend_latch
  import intr_seq_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic rst_req_i,
  input  logic nmi_i,
  input  logic irq_i,
  input  logic i_flag_i,
  input  logic take_i,
  input  src_e take_src_i,
  output logic rst_pend_o,
  output logic nmi_pend_o,
  output logic irq_pend_o
);
  logic nmi_prev_q;
  logic nmi_rise;
  logic rst_pend_q;
  logic nmi_pend_q;
  logic rst_taken;
  logic nmi_taken;

  assign nmi_rise  = nmi_i & ~nmi_prev_q;
  assign rst_taken = take_i && (take_src_i == SRC_RST);
  assign nmi_taken = take_i && (take_src_i == SRC_NMI);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      nmi_prev_q <= 1'b0;
      rst_pend_q <= 1'b1;   // power-on starts a reset sequence
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_i;
      rst_pend_q <= rst_req_i | (rst_pend_q & ~rst_taken);
      nmi_pend_q <= nmi_rise  | (nmi_pend_q & ~nmi_taken);
    end
  end

  assign rst_pend_o = rst_pend_q;
  assign nmi_pend_o = nmi_pend_q;
  assign irq_pend_o = irq_i & ~i_flag_i;
endmodule

// File: rtl/intr_arbiter.sv
// Fixed-priority choice of the source taken at an instruction boundary.
module intr_arbiter
  import intr_seq_pkg::*;
(
  input  logic rst_pend_i,
  input  logic nmi_pend_i,
  input  logic irq_pend_i,
  input  logic end_seq_i,
  output logic any_pend_o,
  output logic take_o,
  output src_e src_o
);
  always_comb begin
    if (rst_pend_i)      src_o = SRC_RST;
    else if (nmi_pend_i) src_o = SRC_NMI;
    else if (irq_pend_i) src_o = SRC_IRQ;
    else                 src_o = SRC_NONE;
  end

  assign any_pend_o = rst_pend_i | nmi_pend_i | irq_pend_i;
  assign take_o     = end_seq_i & any_pend_o;
endmodule

// File: rtl/intr_inprog.sv
// Sequence-active and type flags, updated only at boundaries.
module intr_inprog
  import intr_seq_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic end_seq_i,
  input  logic take_i,
  input  src_e src_i,
  output logic act_o,
  output logic rst_inp_o,
  output logic nmi_inp_o
);
  logic act_q, rst_q, nmi_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      act_q <= 1'b0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else if (take_i) begin
      act_q <= 1'b1;
      rst_q <= (src_i == SRC_RST);
      nmi_q <= (src_i == SRC_NMI);
    end else if (end_seq_i) begin
      act_q <= 1'b0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end
  end

  assign act_o     = act_q;
  assign rst_inp_o = rst_q;
  assign nmi_inp_o = nmi_q;
endmodule

// File: rtl/intr_out_gen.sv
// Per-type constants and sequencer qualifiers.
module intr_out_gen
  import intr_seq_pkg::*;
#(
  parameter int unsigned Q_W       = 3,
  parameter int unsigned PF_STATES = 2
) (
  input  logic             act_i,
  input  logic             rst_inp_i,
  input  logic             nmi_inp_i,
  input  logic             any_pend_i,
  input  logic [Q_W-1:0]   q_i,
  output logic [VEC_W-1:0] vec_lo_o,
  output logic             ir_clr_o,
  output logic             stk_wr_inh_o,
  output logic             pc_adv_o,
  output logic             brk_flag_o,
  output logic             inh_pf_o
);
  localparam logic [Q_W:0] PF_LIMIT = (Q_W+1)'(PF_STATES);

  logic early_state;

  generate
    if (PF_STATES == 0) begin : g_no_window
      assign early_state = 1'b0;
    end else begin : g_window
      assign early_state = ({1'b0, q_i} < PF_LIMIT);
    end
  endgenerate

  always_comb begin
    if (rst_inp_i)      vec_lo_o = VEC_LO_RST;
    else if (nmi_inp_i) vec_lo_o = VEC_LO_NMI;
    else                vec_lo_o = VEC_LO_IRQ;
  end

  assign ir_clr_o     = act_i;
  assign stk_wr_inh_o = rst_inp_i;
  assign pc_adv_o     = ~act_i;
  assign brk_flag_o   = ~act_i;
  assign inh_pf_o     = any_pend_i | (act_i & early_state);
endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int unsigned Q_W       = 3,
  parameter int unsigned PF_STATES = 2
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           rst_req_i,
  input  logic           nmi_i,
  input  logic           irq_i,
  input  logic           i_flag_i,
  input  logic [Q_W-1:0] q_i,
  input  logic           end_seq_i,
  output logic           int_act_o,
  output logic           rst_inp_o,
  output logic           nmi_inp_o,
  output logic           ir_clr_o,
  output logic [7:0]     vec_lo_o,
  output logic           stk_wr_inh_o,
  output logic           pc_adv_o,
  output logic           brk_flag_o,
  output logic           inh_pf_o
);
  logic rst_pend, nmi_pend, irq_pend, any_pend, take;
  src_e src;

  intr_pend_latch u_pend (
    .clk(clk), .arst_n(arst_n), .rst_req_i(rst_req_i), .nmi_i(nmi_i),
    .irq_i(irq_i), .i_flag_i(i_flag_i), .take_i(take), .take_src_i(src),
    .rst_pend_o(rst_pend), .nmi_pend_o(nmi_pend), .irq_pend_o(irq_pend)
  );

  intr_arbiter u_arb (
    .rst_pend_i(rst_pend), .nmi_pend_i(nmi_pend), .irq_pend_i(irq_pend),
    .end_seq_i(end_seq_i), .any_pend_o(any_pend), .take_o(take), .src_o(src)
  );

  intr_inprog u_prog (
    .clk(clk), .arst_n(arst_n), .end_seq_i(end_seq_i), .take_i(take),
    .src_i(src), .act_o(int_act_o), .rst_inp_o(rst_inp_o), .nmi_inp_o(nmi_inp_o)
  );

  intr_out_gen #(.Q_W(Q_W), .PF_STATES(PF_STATES)) u_out (
    .act_i(int_act_o), .rst_inp_i(rst_inp_o), .nmi_inp_i(nmi_inp_o),
    .any_pend_i(any_pend), .q_i(q_i), .vec_lo_o(vec_lo_o), .ir_clr_o(ir_clr_o),
    .stk_wr_inh_o(stk_wr_inh_o), .pc_adv_o(pc_adv_o), .brk_flag_o(brk_flag_o),
    .inh_pf_o(inh_pf_o)
  );
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int unsigned Q_W = 3
) (
  input logic           clk,
  input logic           arst_n,
  input logic           end_seq_i,
  input logic [Q_W-1:0] q_i,
  input logic           int_act_o,
  input logic           rst_inp_o,
  input logic           nmi_inp_o,
  input logic [7:0]     vec_lo_o,
  input logic           pc_adv_o,
  input logic           brk_flag_o,
  input logic           inh_pf_o
);
  // R3: a type flag is only ever raised together with the active flag
  assert_type_needs_act_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_inp_o) || $rose(nmi_inp_o) |-> int_act_o);

  assert_type_exclusive_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({rst_inp_o, nmi_inp_o}));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !end_seq_i |=> $stable(int_act_o) && $stable(rst_inp_o) && $stable(nmi_inp_o));

  assert_idle_end_clears_R7: assert property (@(posedge clk) disable iff (!arst_n)
    end_seq_i && !inh_pf_o |=> !int_act_o && !rst_inp_o && !nmi_inp_o);

  assert_take_sets_act_R2: assert property (@(posedge clk) disable iff (!arst_n)
    end_seq_i && inh_pf_o && !int_act_o |=> int_act_o);

  assert_reset_vector_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_inp_o |-> vec_lo_o == 8'hFC);

  assert_hw_no_break_R10: assert property (@(posedge clk) disable iff (!arst_n)
    int_act_o |-> !pc_adv_o && !brk_flag_o);

  assert_pf_window_R11: assert property (@(posedge clk) disable iff (!arst_n)
    int_act_o && q_i == '0 |-> inh_pf_o);
endmodule

bind intr_seq_ctrl intr_seq_chk #(.Q_W(Q_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .end_seq_i(end_seq_i), .q_i(q_i),
  .int_act_o(int_act_o), .rst_inp_o(rst_inp_o), .nmi_inp_o(nmi_inp_o),
  .vec_lo_o(vec_lo_o), .pc_adv_o(pc_adv_o), .brk_flag_o(brk_flag_o),
  .inh_pf_o(inh_pf_o)
);

// File: tb/intr_seq_ctrl_tb_top.sv
module intr_seq_ctrl_tb_top;
  localparam int Q_W = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_req_i = 1'b0, nmi_i = 1'b0, irq_i = 1'b0, i_flag_i = 1'b1;
  logic [Q_W-1:0] q_i = '0;
  logic end_seq_i = 1'b0;
  logic int_act_o, rst_inp_o, nmi_inp_o, ir_clr_o, stk_wr_inh_o;
  logic pc_adv_o, brk_flag_o, inh_pf_o;
  logic [7:0] vec_lo_o;

  int checks = 0;
  int fails = 0;

  // model state
  bit m_rp, m_np, m_nq, m_act, m_ri, m_ni;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_seq_ctrl #(.Q_W(Q_W), .PF_STATES(2)) dut_i (
    .clk(clk), .arst_n(arst_n), .rst_req_i(rst_req_i), .nmi_i(nmi_i),
    .irq_i(irq_i), .i_flag_i(i_flag_i), .q_i(q_i), .end_seq_i(end_seq_i),
    .int_act_o(int_act_o), .rst_inp_o(rst_inp_o), .nmi_inp_o(nmi_inp_o),
    .ir_clr_o(ir_clr_o), .vec_lo_o(vec_lo_o), .stk_wr_inh_o(stk_wr_inh_o),
    .pc_adv_o(pc_adv_o), .brk_flag_o(brk_flag_o), .inh_pf_o(inh_pf_o)
  );

  task automatic chk(input string req, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) @%0t: actual=%0h expected=%0h", req, ctx, $time, act, exp);
    end
  endtask

  function automatic bit m_pend();
    return m_rp | m_np | (irq_i & ~i_flag_i);
  endfunction

  task automatic compare(input string ctx);
    int exp_vec;
    exp_vec = m_ri ? 'hFC : (m_ni ? 'hFA : 'hFE);
    chk("R2", ctx, int_act_o, m_act);
    chk("R2", ctx, ir_clr_o, m_act);
    chk("R3", ctx, rst_inp_o, m_ri);
    chk("R5", ctx, nmi_inp_o, m_ni);
    chk("R8", ctx, vec_lo_o, exp_vec);
    chk("R9", ctx, stk_wr_inh_o, m_ri);
    chk("R10", ctx, pc_adv_o, !m_act);
    chk("R10", ctx, brk_flag_o, !m_act);
    chk("R11", ctx, inh_pf_o, m_pend() | (m_act && q_i < 2));
  endtask

  task automatic model_edge();
    bit take, s_rst, s_nmi, rise;
    take  = end_seq_i && m_pend();
    s_rst = m_rp;
    s_nmi = !m_rp && m_np;
    rise  = nmi_i && !m_nq;
    m_nq = nmi_i;
    m_rp = rst_req_i | (m_rp & !(take && s_rst));
    m_np = rise | (m_np & !(take && s_nmi));
    if (take) begin
      m_act = 1; m_ri = s_rst; m_ni = s_nmi;
    end else if (end_seq_i) begin
      m_act = 0; m_ri = 0; m_ni = 0;
    end
  endtask

  // one cycle: drive after negedge, compare, then let the edge happen
  task automatic step(input bit rr, input bit nm, input bit iq, input bit ifl,
                      input int q, input bit es, input string ctx);
    @(negedge clk);
    rst_req_i = rr; nmi_i = nm; irq_i = iq; i_flag_i = ifl;
    q_i = Q_W'(q); end_seq_i = es;
    #1;
    compare(ctx);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_rp = 1; m_np = 0; m_nq = 0; m_act = 0; m_ri = 0; m_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "reset", int_act_o, 0);
    chk("R1", "reset", rst_inp_o, 0);
    chk("R1", "reset", nmi_inp_o, 0);
    chk("R1", "reset", inh_pf_o, 1);
    @(posedge clk);
    model_edge();

    // power-on reset taken at first boundary (R2, R3, R9)
    step(0,0,0,1,0,1,"R2 take reset");
    for (int q = 0; q < 6; q++) step(0,0,0,1,q,(q==5),"R9 reset sequence");
    // R7: idle boundary after end clears
    for (int q = 0; q < 3; q++) step(0,0,0,1,q,(q==2),"R7 idle end");
    // R4: IRQ masked, then unmasked
    for (int q = 0; q < 3; q++) step(0,0,1,1,q,(q==2),"R4 masked irq");
    for (int q = 0; q < 3; q++) step(0,0,1,0,q,(q==2),"R4 irq taken");
    // R12: sequence ends with NMI pending -> chains into NMI
    step(0,1,0,0,0,0,"R5 nmi edge");
    for (int q = 0; q < 4; q++) step(0,1,0,0,q,(q==3),"R12 chain to nmi");
    // R5: held level gives no second request
    for (int q = 0; q < 4; q++) step(0,1,0,0,q,(q==3),"R5 held level");
    step(0,0,0,0,0,0,"R5 release");
    // R5: new edge coinciding with NMI capture
    step(0,1,0,0,0,0,"R5 first edge");
    step(0,0,0,0,1,0,"R5 low");
    step(0,1,0,0,2,1,"R5 edge at capture");
    for (int q = 0; q < 4; q++) step(0,1,0,0,q,(q==3),"R5 second nmi");
    // R3/R6: reset beats NMI and IRQ; held request re-pends
    step(1,0,1,0,0,0,"R6 reset req");
    step(1,1,1,0,1,1,"R3 priority");
    step(1,1,1,0,0,0,"R6 held");
    step(0,1,1,0,1,1,"R6 re-take reset");
    for (int q = 0; q < 4; q++) step(0,0,1,0,q,(q==3),"R12 reset to irq");
    for (int q = 0; q < 4; q++) step(0,0,0,0,q,(q==3),"R7 final end");

    // random traffic, including boundary collisions
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      step((r % 23) == 0, r[4], r[5] & r[6], r[7], (r >> 8) % 8,
           r[11] | r[12], "R12 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule